// File: doc/BRIEF.md
# Load-Use Stall Controller

This block guards an in-order instruction pipeline against the one data dependence that operand bypassing cannot cover. That case is a load sitting in the execute stage whose result is needed by the instruction being decoded right behind it. The block does not compare register numbers again. It reuses the two operand-bypass select codes that the forwarding logic has already computed. A select value of 1 means "take the value from the execute stage". If such a select meets a memory-read in the execute stage, the hazard is present.

On a hit the block freezes the program counter and the instruction register for one cycle, so the dependent instruction is decoded again. It also replaces the control word entering execute with all zeros, which turns that slot into a no-op. The load moves on to the memory stage. On the next cycle the forwarding logic can then pick up its data from there with select code 2, and the stall drops by itself. A small model of the PC, the instruction register and the execute-stage control register is included, so the freeze and the bubble can be observed at the ports.

Top module: `load_use_stall_ctl`

## Requirements
- R1: While `rst_n` is low, `pc_q`, `ir_q` and `ex_ctl_q` are all zero. The three stall outputs are low.
- R2: The stall is asserted in the same cycle, combinationally, exactly when bit 6 (memory read) of `ex_ctl_q` is 1 and either `fwd_a` or `fwd_b` equals 1. The select encoding is: 0 = register file, 1 = execute stage, 2 = memory stage, 3 = write-back stage.
- R3: `pc_wr_dis`, `ir_dis` and `bubble_sel` always carry the same value.
- R4: After a clock edge at which the stall was asserted, `pc_q` and `ir_q` still hold their values from before that edge.
- R5: After a clock edge at which the stall was asserted, `ex_ctl_q` is all zero. This includes bit 7 (register write) and bit 5 (memory write).
- R6: After a clock edge without a stall, `pc_q` has advanced by `PC_STEP` modulo 2^`PC_W`. `ir_q` holds the value of `fetch_instr` and `ex_ctl_q` holds the value of `dec_ctl` from before the edge. The control word bits are: [7] register write, [6] memory read, [5] memory write, [4] write-back select, [3] ALU operand select, [2:0] ALU operation.
- R7: A single load-use hazard costs exactly one cycle. In the cycle after a stall the stall is low, whatever the select codes are.
- R8: No stall occurs when the execute stage holds a load and both selects are 0, 2 or 3. No stall occurs when a select is 1 but the execute stage does not hold a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_instr | input | INSTR_W | Instruction word arriving from fetch |
| dec_ctl | input | 8 | Control word decoded for the instruction in decode |
| fwd_a | input | 2 | Bypass select of the first operand |
| fwd_b | input | 2 | Bypass select of the second operand |
| pc_wr_dis | output | 1 | Program-counter write disable |
| ir_dis | output | 1 | Instruction-register load disable |
| bubble_sel | output | 1 | Selects an all-zero control word into execute |
| pc_q | output | PC_W | Program counter |
| ir_q | output | INSTR_W | Instruction register |
| ex_ctl_q | output | 8 | Execute-stage control register |

## Verification
The only state here is the execute-stage control word, together with the PC and the instruction register. A wrong value in the control register appears one edge later as a false or missing stall on the three disable outputs. It also shows at once on `ex_ctl_q`. A freeze that fails to hold shows as a PC step in the very next cycle. A stall that persists past its single cycle shows as a second frozen PC value. The tests aim at these single-edge effects: back-to-back loads, a hit on the second operand only, and loads followed by far or independent users.

// File: rtl/lus_pkg.sv
`timescale 1ns/1ps
package lus_pkg;

  localparam int ALU_OP_W = 3;

  typedef struct packed {
    logic                reg_wr;
    logic                mem_rd;
    logic                mem_wr;
    logic                wb_sel;
    logic                alu_src;
    logic [ALU_OP_W-1:0] alu_op;
  } ex_ctl_t;

  localparam int CTL_W = $bits(ex_ctl_t);

  typedef enum logic [1:0] {
    BYP_REGFILE = 2'd0,
    BYP_EXEC    = 2'd1,
    BYP_MEMORY  = 2'd2,
    BYP_WRBACK  = 2'd3
  } byp_sel_e;

  // A dependence on the execute stage while that stage is reading memory.
  function automatic logic load_use_hit(input logic       ex_reads_mem,
                                        input logic [1:0] sel_a,
                                        input logic [1:0] sel_b);
    return ex_reads_mem &&
           ((sel_a == BYP_EXEC) || (sel_b == BYP_EXEC));
  endfunction

endpackage

// File: rtl/lus_hazard_detect.sv
`timescale 1ns/1ps
module lus_hazard_detect
  import lus_pkg::*;
(
  input  logic       ex_mem_rd,
  input  logic [1:0] fwd_a,
  input  logic [1:0] fwd_b,
  output logic       stall
);

  logic a_needs_exec;
  logic b_needs_exec;

  assign a_needs_exec = (fwd_a == BYP_EXEC);
  assign b_needs_exec = (fwd_b == BYP_EXEC);
  assign stall        = load_use_hit(ex_mem_rd, fwd_a, fwd_b);

  // R8: selects pointing at later stages never cause a freeze
  always_comb begin
    p_far_select_no_stall_r8: assert (a_needs_exec || b_needs_exec || !stall);
  end

endmodule

// File: rtl/lus_fetch_hold.sv
`timescale 1ns/1ps
module lus_fetch_hold #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [INSTR_W-1:0] fetch_instr,
  output logic [PC_W-1:0]    pc_q,
  output logic [INSTR_W-1:0] ir_q
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  function automatic logic [PC_W-1:0] advance(input logic [PC_W-1:0] cur);
    return cur + STEP_V;
  endfunction

  logic [PC_W-1:0] pc_next;
  assign pc_next = advance(pc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
    end else if (!hold) begin
      pc_q <= pc_next;
      ir_q <= fetch_instr;
    end
  end

  // R4: a freeze keeps both fetch-side registers
  p_freeze_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pc_q == $past(pc_q)) && (ir_q == $past(ir_q)));

  // R6: otherwise the PC moves by one step and the IR captures the fetch word
  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (pc_q == $past(pc_q) + STEP_V) && (ir_q == $past(fetch_instr)));

endmodule

// File: rtl/lus_ex_ctl_reg.sv
`timescale 1ns/1ps
module lus_ex_ctl_reg
  import lus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bubble,
  input  logic [CTL_W-1:0] dec_ctl,
  output logic [CTL_W-1:0] ex_ctl_q,
  output logic             ex_mem_rd
);

  ex_ctl_t stage_q;
  ex_ctl_t stage_d;

  assign stage_d = bubble ? ex_ctl_t'('0) : ex_ctl_t'(dec_ctl);

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign ex_ctl_q  = stage_q;
  assign ex_mem_rd = stage_q.mem_rd;

  // R5: a bubble leaves no write enable behind
  p_bubble_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (ex_ctl_q == '0) && !stage_q.reg_wr && !stage_q.mem_wr);

  // R6: a normal cycle passes the decoded word through unchanged
  p_ctl_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble |=> ex_ctl_q == $past(dec_ctl));

endmodule

// File: rtl/load_use_stall_ctl.sv
`timescale 1ns/1ps
module load_use_stall_ctl
  import lus_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic [CTL_W-1:0]   dec_ctl,
  input  logic [1:0]         fwd_a,
  input  logic [1:0]         fwd_b,
  output logic               pc_wr_dis,
  output logic               ir_dis,
  output logic               bubble_sel,
  output logic [PC_W-1:0]    pc_q,
  output logic [INSTR_W-1:0] ir_q,
  output logic [CTL_W-1:0]   ex_ctl_q
);

  logic ex_mem_rd;
  logic load_use_stall;

  lus_hazard_detect u_detect (
    .ex_mem_rd (ex_mem_rd),
    .fwd_a     (fwd_a),
    .fwd_b     (fwd_b),
    .stall     (load_use_stall)
  );

  lus_fetch_hold #(
    .PC_W    (PC_W),
    .INSTR_W (INSTR_W),
    .PC_STEP (PC_STEP)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (load_use_stall),
    .fetch_instr (fetch_instr),
    .pc_q        (pc_q),
    .ir_q        (ir_q)
  );

  lus_ex_ctl_reg u_exreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bubble    (load_use_stall),
    .dec_ctl   (dec_ctl),
    .ex_ctl_q  (ex_ctl_q),
    .ex_mem_rd (ex_mem_rd)
  );

  assign pc_wr_dis  = load_use_stall;
  assign ir_dis     = load_use_stall;
  assign bubble_sel = load_use_stall;

  // R7: the bubble removes the load from execute, so a freeze never repeats
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_use_stall |=> !load_use_stall);

  // R2: a freeze implies a load is present in execute
  p_stall_needs_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_use_stall |-> ex_ctl_q[6]);

endmodule

// File: tb/load_use_stall_ctl_test.sv
`timescale 1ns/1ps
module load_use_stall_ctl_test;

  localparam int PW = 32;
  localparam int IW = 32;
  localparam int STEP = 4;

  localparam logic [7:0] C_ALU   = 8'b1000_0001;
  localparam logic [7:0] C_LOAD  = 8'b1101_1000;
  localparam logic [7:0] C_STORE = 8'b0010_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] fetch_instr = '0;
  logic [7:0]    dec_ctl = '0;
  logic [1:0]    fwd_a = '0;
  logic [1:0]    fwd_b = '0;
  logic          pc_wr_dis, ir_dis, bubble_sel;
  logic [PW-1:0] pc_q;
  logic [IW-1:0] ir_q;
  logic [7:0]    ex_ctl_q;

  always #2 clk = ~clk;

  load_use_stall_ctl #(.PC_W(PW), .INSTR_W(IW), .PC_STEP(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .dec_ctl(dec_ctl),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_wr_dis(pc_wr_dis), .ir_dis(ir_dis),
    .bubble_sel(bubble_sel), .pc_q(pc_q), .ir_q(ir_q), .ex_ctl_q(ex_ctl_q)
  );

  typedef struct {
    logic [PW-1:0] pc;
    logic [IW-1:0] ir;
    logic [7:0]    ex;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [PW-1:0] pc_m = '0;
  logic [IW-1:0] ir_m = '0;
  logic [7:0]    ex_m = '0;

  task automatic step(input logic [IW-1:0] ins, input logic [7:0] ctl,
                      input logic [1:0] fa, input logic [1:0] fb, input string tag);
    logic want;
    exp_t e;
    fetch_instr = ins; dec_ctl = ctl; fwd_a = fa; fwd_b = fb;
    #1;
    want = ex_m[6] && (fa == 2'd1 || fb == 2'd1);
    n_run++;
    if ({pc_wr_dis, ir_dis, bubble_sel} !== {3{want}}) begin
      n_fail++;
      $display("FAIL %s R3 stall outputs act=%b exp=%b", tag,
               {pc_wr_dis, ir_dis, bubble_sel}, {3{want}});
    end
    if (!want) begin
      pc_m = pc_m + PW'(STEP);
      ir_m = ins;
      ex_m = ctl;
    end else begin
      ex_m = '0;
    end
    e.pc = pc_m; e.ir = ir_m; e.ex = ex_m; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compares registered state one edge after each driven step
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run += 3;
        if (pc_q !== e.pc) begin
          n_fail++; $display("FAIL %s pc act=%h exp=%h", e.tag, pc_q, e.pc);
        end
        if (ir_q !== e.ir) begin
          n_fail++; $display("FAIL %s ir act=%h exp=%h", e.tag, ir_q, e.ir);
        end
        if (ex_ctl_q !== e.ex) begin
          n_fail++; $display("FAIL %s ex_ctl act=%h exp=%h", e.tag, ex_ctl_q, e.ex);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (pc_q !== '0 || ir_q !== '0 || ex_ctl_q !== '0 ||
        {pc_wr_dis, ir_dis, bubble_sel} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 reset state act=%h/%h/%h/%b exp=0/0/0/000",
               pc_q, ir_q, ex_ctl_q, {pc_wr_dis, ir_dis, bubble_sel});
    end
    rst_n = 1'b1;

    step(32'hA000_0001, C_ALU,   2'd0, 2'd0, "R6 plain");
    step(32'hA000_0002, C_ALU,   2'd1, 2'd0, "R8 alu in ex");
    step(32'hA000_0003, C_LOAD,  2'd0, 2'd1, "R8 alu in ex b");
    step(32'hA000_0004, C_ALU,   2'd1, 2'd0, "R2 R4 R5 hit a");
    step(32'hA000_0004, C_ALU,   2'd2, 2'd0, "R7 after stall");
    step(32'hA000_0005, C_LOAD,  2'd0, 2'd0, "R6 load");
    step(32'hA000_0006, C_ALU,   2'd0, 2'd0, "R8 independent");
    step(32'hA000_0007, C_ALU,   2'd2, 2'd3, "R8 two behind");
    step(32'hA000_0008, C_LOAD,  2'd0, 2'd0, "R6 load");
    step(32'hA000_0009, C_STORE, 2'd0, 2'd1, "R2 R4 R5 hit b");
    step(32'hA000_0009, C_STORE, 2'd0, 2'd2, "R7 after stall b");
    step(32'hA000_000A, C_LOAD,  2'd0, 2'd0, "R6 load");
    step(32'hA000_000B, C_ALU,   2'd3, 2'd2, "R8 far selects");
    step(32'hA000_000C, C_LOAD,  2'd0, 2'd0, "R6 load");
    step(32'hA000_000D, C_LOAD,  2'd1, 2'd1, "R2 R4 R5 load on load");
    step(32'hA000_000D, C_LOAD,  2'd1, 2'd1, "R7 selects stay 1");
    step(32'hA000_000E, C_ALU,   2'd1, 2'd0, "R2 second load hit");
    step(32'hA000_000E, C_ALU,   2'd2, 2'd0, "R7 recover");
    step(32'hA000_000F, C_ALU,   2'd0, 2'd0, "R6 drain");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule